// File: doc/BRIEF.md
# TDM Time-Slot Interchange with Per-Channel Delay Selection

This block switches byte-wide channels between positions in a time-division frame of 32 slots. One clock cycle is one slot. Every received byte is stored in a data memory, addressed by frame bank and slot number. For each outgoing slot, a connection table supplies two things: the source slot to read and a delay mode bit. The frame pulse marks slot 0. A free-running slot counter and a frame bank index, counted modulo three, run the whole exchange.

The delay mode bit picks between two behaviours. The latency-oriented mode forwards a byte as soon as the slot distance allows, which suits voice traffic. The integrity-oriented mode delays every channel by exactly two frames, so that bytes collected in one frame leave together in one frame, which suits wideband data spread over several slots. A single-cycle write port updates one connection entry at a time while switching continues.

Top module: `tsi_switch`

## Requirements
- R1: While reset is asserted, and in the first slot after its release, `tx_data` is 0. Reset clears every data-memory byte to 0. Reset sets connection entry t to source slot t with mode bit 0.
- R2: A high `frame_pulse` makes the current slot 0. Otherwise the slot advances by one each cycle and wraps from 31 to 0. The byte for output channel t is driven on `tx_data` during the slot after slot t.
- R3: Mode bit 0 (latency mode) with destination t ≥ source s + 3 takes the byte received in slot s of the same frame.
- R4: Mode bit 0 with t ≤ s + 2 takes the byte received in slot s of the previous frame. This includes every case where t < s.
- R5: Mode bit 1 (integrity mode) takes the byte received in slot s two frames earlier, whatever t and s are. Slot 31 switched to slot 0 gives the shortest span and slot 0 switched to slot 31 gives the longest.
- R6: A write through `cm_we` during slot k is used by every read of that entry from slot k+1 onward. A read of the same entry during slot k still uses the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High for one cycle in slot 0 |
| rx_data | input | 8 | Byte received in the current slot |
| cm_we | input | 1 | Connection entry write strobe |
| cm_addr | input | 5 | Output slot whose entry is written |
| cm_src | input | 5 | Source slot written to the entry |
| cm_const | input | 1 | Mode bit written: 0 latency, 1 integrity |
| tx_data | output | 8 | Byte of the previous slot's output channel |

## Verification
Every received byte encodes its frame and slot, so a byte read from the wrong bank or the wrong slot produces a distinct wrong value. The first frames run on the reset connection table. This shows that fresh memory reads zero and that the identity mapping lands one frame late. A mixed table of strided sources and scattered integrity-mode entries then separates same-frame, previous-frame and two-frame reads. A reversed table in integrity mode covers the 31→0 and 0→31 extremes. A final table alternates slot distances of exactly 2 and 3, which finds an off-by-one in the threshold. Each entry is rewritten during its own slot, and the expected value for that slot uses the old entry.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
    localparam int NUM_BANKS = 3;

    typedef enum logic {
        DLY_LATENCY = 1'b0,
        DLY_FRAME   = 1'b1
    } dly_mode_e;

    function automatic logic [1:0] bank_back(input logic [1:0] bank, input int unsigned n);
        logic [1:0] b;
        b = bank;
        for (int i = 0; i < 2; i++) begin
            if (i < int'(n)) b = (b == 2'd0) ? 2'd2 : b - 2'd1;
        end
        return b;
    endfunction
endpackage

// File: rtl/tsi_slot_timer.sv
`timescale 1ns/1ps
module tsi_slot_timer #(
    parameter int SLOTS = 32,
    parameter int AW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    output logic [AW-1:0] slot,
    output logic [1:0]    bank_cur,
    output logic [1:0]    bank_m1,
    output logic [1:0]    bank_m2
);
    import tsi_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [1:0]    bank;
    } timer_t;

    timer_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        slot = frame_pulse ? '0 : st_q.cnt;
        if (slot == LAST) begin
            st_d.cnt  = '0;
            st_d.bank = (st_q.bank == 2'(NUM_BANKS - 1)) ? 2'd0 : st_q.bank + 2'd1;
        end else begin
            st_d.cnt = slot + AW'(1);
        end
        bank_cur = st_q.bank;
        bank_m1  = bank_back(st_q.bank, 1);
        bank_m2  = bank_back(st_q.bank, 2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem #(
    parameter int SLOTS = 32,
    parameter int AW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] wsrc,
    input  logic          wmode,
    input  logic [AW-1:0] raddr,
    output logic [AW-1:0] rsrc,
    output logic          rmode
);
    typedef struct packed {
        logic [SLOTS-1:0][AW-1:0] src;
        logic [SLOTS-1:0]         mode;
    } cm_t;

    function automatic cm_t cm_reset_value();
        cm_t v;
        for (int i = 0; i < SLOTS; i++) begin
            v.src[i]  = AW'(i);
            v.mode[i] = 1'b0;
        end
        return v;
    endfunction

    cm_t cm_q, cm_d;

    always_comb begin
        cm_d = cm_q;
        if (we) begin
            cm_d.src[waddr]  = wsrc;
            cm_d.mode[waddr] = wmode;
        end
        rsrc  = cm_q.src[raddr];
        rmode = cm_q.mode[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= cm_reset_value();
        else        cm_q <= cm_d;
    end
endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem #(
    parameter int SLOTS = 32,
    parameter int W     = 8,
    parameter int AW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [1:0]    rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    import tsi_pkg::*;

    typedef struct packed {
        logic [NUM_BANKS-1:0][SLOTS-1:0][W-1:0] mem;
    } dm_t;

    dm_t dm_q, dm_d;

    always_comb begin
        dm_d = dm_q;
        dm_d.mem[wr_bank][wr_addr] = wr_data;
        rd_data = dm_q.mem[rd_bank][rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dm_q <= '0;
        else        dm_q <= dm_d;
    end
endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch #(
    parameter int SLOTS = 32,
    parameter int W     = 8,
    parameter int AW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    input  logic [W-1:0]  rx_data,
    input  logic          cm_we,
    input  logic [AW-1:0] cm_addr,
    input  logic [AW-1:0] cm_src,
    input  logic          cm_const,
    output logic [W-1:0]  tx_data
);
    import tsi_pkg::*;

    localparam int MIN_GAP = 3;

    logic [AW-1:0] slot_w;
    logic [1:0]    bank_cur, bank_m1, bank_m2;
    logic [AW-1:0] src_w;
    logic          mode_w;
    logic [1:0]    rd_bank;
    logic [W-1:0]  rd_data;
    logic [AW:0]   dst_ext, src_gap;

    typedef struct packed {
        logic [W-1:0] tx;
    } out_t;

    out_t out_q, out_d;

    tsi_slot_timer #(.SLOTS(SLOTS), .AW(AW)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .slot(slot_w), .bank_cur(bank_cur), .bank_m1(bank_m1), .bank_m2(bank_m2)
    );

    tsi_conn_mem #(.SLOTS(SLOTS), .AW(AW)) u_cm (
        .clk(clk), .rst_n(rst_n), .we(cm_we), .waddr(cm_addr), .wsrc(cm_src),
        .wmode(cm_const), .raddr(slot_w), .rsrc(src_w), .rmode(mode_w)
    );

    tsi_data_mem #(.SLOTS(SLOTS), .W(W), .AW(AW)) u_dm (
        .clk(clk), .rst_n(rst_n), .wr_bank(bank_cur), .wr_addr(slot_w),
        .wr_data(rx_data), .rd_bank(rd_bank), .rd_addr(src_w), .rd_data(rd_data)
    );

    always_comb begin
        dst_ext = {1'b0, slot_w};
        src_gap = {1'b0, src_w} + (AW+1)'(MIN_GAP);
        if (dly_mode_e'(mode_w) == DLY_FRAME) rd_bank = bank_m2;
        else if (dst_ext >= src_gap)          rd_bank = bank_cur;
        else                                  rd_bank = bank_m1;
        out_d.tx = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tx_data = out_q.tx;
endmodule

// File: rtl/tsi_switch_chk.sv
`timescale 1ns/1ps
module tsi_switch_chk #(
    parameter int SLOTS = 32,
    parameter int W     = 8,
    parameter int AW    = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_pulse,
    input logic [AW-1:0] slot,
    input logic [1:0]    bank,
    input logic [W-1:0]  tx_data
);
    localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

    // R1
    tx_cleared_chk: assert property (@(posedge clk) !rst_n |=> tx_data == '0);

    // R2
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (frame_pulse || slot == AW'(1)));

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == LAST) |=> (frame_pulse || slot == '0));

    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != LAST) |=> $stable(bank));
endmodule

bind tsi_switch tsi_switch_chk #(.SLOTS(SLOTS), .W(W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .slot(slot_w), .bank(bank_cur), .tx_data(tx_data)
);

// File: tb/tsi_switch_bench.sv
`timescale 1ns/1ps
module tsi_switch_bench;
    localparam int SLOTS  = 32;
    localparam int NFRM   = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic [7:0] rx_data = '0;
    logic       cm_we = 1'b0;
    logic [4:0] cm_addr = '0;
    logic [4:0] cm_src = '0;
    logic       cm_const = 1'b0;
    logic [7:0] tx_data;

    always #5 clk = ~clk;

    tsi_switch u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rx_data(rx_data),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_src(cm_src), .cm_const(cm_const),
        .tx_data(tx_data)
    );

    typedef struct {
        logic [7:0] exp;
        int         ch;
        int         frm;
        string      tag;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [7:0] hist [0:NFRM-1][0:SLOTS-1];
    int         m_src  [0:SLOTS-1];
    bit         m_mode [0:SLOTS-1];
    bit         s_we   [0:SLOTS-1];
    int         s_src  [0:SLOTS-1];
    bit         s_mode [0:SLOTS-1];

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic drive_slot(input int g, input int t);
        item_t it;
        int    s;
        int    f;
        @(negedge clk);
        rst_n       = 1'b1;
        frame_pulse = (t == 0);
        rx_data     = 8'((g * 53 + t * 11 + 7) & 255);
        hist[g][t]  = rx_data;
        cm_we       = s_we[t];
        cm_addr     = 5'(t);
        cm_src      = 5'(s_src[t]);
        cm_const    = s_mode[t];
        s = m_src[t];
        if (m_mode[t])     f = g - 2;   // R5
        else if (t >= s+3) f = g;       // R3
        else               f = g - 1;   // R4
        it.exp = (f < 0) ? 8'h00 : hist[f][s];
        it.ch  = t;
        it.frm = g;
        if (s_we[t])     it.tag = "R6";
        else if (f < 0)  it.tag = "R1";
        else if (m_mode[t]) it.tag = "R5";
        else if (f == g) it.tag = "R3";
        else             it.tag = "R4";
        if (t == 0) it.tag = {"R2/", it.tag};
        sb.push_back(it);
        if (s_we[t]) begin
            m_src[t]  = s_src[t];
            m_mode[t] = s_mode[t];
        end
    endtask

    // monitor: the byte for slot t is visible after the edge that ends slot t (R2)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (tx_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s frame %0d ch %0d: actual %02h expected %02h",
                             it.tag, it.frm, it.ch, tx_data, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            m_src[i]  = i;
            m_mode[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (tx_data !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: actual %02h expected 00", tx_data);
        end
        for (int g = 0; g < NFRM; g++) begin
            for (int i = 0; i < SLOTS; i++) begin
                s_we[i] = 1'b0; s_src[i] = 0; s_mode[i] = 1'b0;
                if (g == 1) begin
                    s_we[i] = 1'b1; s_src[i] = (i * 7 + 3) % SLOTS; s_mode[i] = (i % 4 == 0);
                end else if (g == 4) begin
                    // R5 extremes: entry 0 takes slot 31, entry 31 takes slot 0
                    s_we[i] = 1'b1; s_src[i] = SLOTS - 1 - i; s_mode[i] = 1'b1;
                end else if (g == 8) begin
                    // R3/R4 boundary: distances alternate 2 and 3
                    s_we[i] = 1'b1; s_src[i] = (i % 2 == 1) ? (i + 29) % SLOTS : (i + 30) % SLOTS;
                    s_mode[i] = 1'b0;
                end
            end
            for (int t = 0; t < SLOTS; t++) drive_slot(g, t);
        end
        @(negedge clk);
        cm_we = 1'b0;
        frame_pulse = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end
endmodule